// File: doc/BRIEF.md
# Pulse-Limited Phase-Frequency Detector

This block compares a reference clock with a feedback clock from a frequency synthesizer's divider and produces pump-up and pump-down commands for a current-steering charge pump. Both clock inputs are sampled by a faster system clock. Each input passes through a synchronizer and a rising-edge detector. A small state machine then decides which edge came first. If the reference edge leads, the block raises pump-up, which asks for a higher oscillator frequency. If the feedback edge leads, it raises pump-down. Once both commands are active, the block holds them together for a programmable number of extra cycles and then clears them in the same cycle. This gives a guaranteed overlap in every comparison, so there is no dead zone.

While the loop is acquiring lock, the pump-up command can be cut short so that the frequency overshoots less. A period meter counts system clocks between successive reference rising edges. The limit is a quarter or an eighth of that measured period. Pump-down is never cut. Each command leaves the block on a registered true output and a registered complement output, both loaded in the same cycle.

Top module: `pfd_pulse_limit`

## Requirements
- R1: A reference rising edge that arrives while the detector is idle and without a simultaneous feedback edge raises pump_up alone. It stays up until the feedback edge is seen. A feedback edge that arrives first raises pump_dn alone in the same way. Measured at the outputs, the single-command interval equals the lead in system-clock cycles.
- R2: Once both commands are active, they fall in the same cycle. Reference and feedback edges detected in the same cycle give pump_up and pump_dn pulses of equal length.
- R3: Every comparison ends with pump_up and pump_dn both high for exactly ovl_cycles+1 consecutive cycles. ovl_cycles is a 4-bit value from 0 to 15.
- R4: When limit_en is 1, pump_up stays high during a reference-leading interval for at most `lim` cycles, where `lim` = measured period >> 2 when limit_sel = 0 and period >> 3 when limit_sel = 1, with a floor of 1. When limit_en is 0, pump_up is never cut.
- R5: pump_dn is never shortened by the limiter, whatever limit_en and limit_sel are set to.
- R6: In every cycle, pump_up_b is the inverse of pump_up and pump_dn_b is the inverse of pump_dn, with no cycle of skew between them.
- R7: The measured period is the number of system-clock cycles between two successive detected reference rising edges. It changes only when a reference rising edge is detected. Until a second edge has been seen, it reads as the maximum value.
- R8: A synchronous active-high rst drives pump_up and pump_dn low and both complements high on the next clock edge, even in the middle of a comparison.
- R9: If the reference clock stops, the period counter saturates at 2^PER_W-1 (4095 by default) instead of wrapping. The limit that follows a long gap is therefore derived from the saturated value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples both input clocks |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference clock, asynchronous to clk |
| fbk_in | input | 1 | Feedback (divided oscillator) clock, asynchronous to clk |
| limit_en | input | 1 | 1 enables the pump-up width limiter |
| limit_sel | input | 1 | Limiter fraction: 0 = period/4, 1 = period/8 |
| ovl_cycles | input | OVL_W | Extra overlap cycles with both commands high |
| pump_up | output | 1 | Raise oscillator frequency |
| pump_up_b | output | 1 | Complement of pump_up |
| pump_dn | output | 1 | Lower oscillator frequency |
| pump_dn_b | output | 1 | Complement of pump_dn |

## Verification
A wrong state in the comparison machine appears at the outputs within one comparison. The pulse lengths measured on pump_up and pump_dn no longer match the lead and the overlap setting, or a command never clears. A bad period measurement or a counter that wraps stays hidden until the limiter is enabled. It then shows up as a pump-up pulse cut at the wrong length in the first comparison after the reference edge that loaded the bad value. A broken complement path shows up within one cycle as equal true and complement levels.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_UP   = 2'd1,
    ST_DN   = 2'd2,
    ST_OVL  = 2'd3
  } pfd_state_e;
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sh_q[STAGES-1];
  end

  assign rise = sh_q[STAGES-1] & ~last_q;

  // a detected edge is never reported in two consecutive cycles
  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/pfd_period_meter.sv
module pfd_period_meter #(
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [PER_W-1:0] period
);
  localparam logic [PER_W-1:0] CNT_MAX = '1;
  localparam logic [PER_W-1:0] CNT_ONE = PER_W'(1);

  logic [PER_W-1:0] cnt_q;
  logic             seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      period <= CNT_MAX;
    end else if (tick) begin
      cnt_q  <= CNT_ONE;
      seen_q <= 1'b1;
      if (seen_q) period <= cnt_q;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + CNT_ONE;
    end
  end

  assert_saturate_R9: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX && !tick) |=> (cnt_q == CNT_MAX));

  assert_period_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(period));
endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
#(
  parameter int PER_W = 12,
  parameter int OVL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_rise,
  input  logic             fb_rise,
  input  logic             limit_en,
  input  logic             limit_sel,
  input  logic [OVL_W-1:0] ovl,
  input  logic [PER_W-1:0] period,
  output logic             up_o,
  output logic             upb_o,
  output logic             dn_o,
  output logic             dnb_o
);
  localparam logic [PER_W-1:0] LEAD_MAX = '1;
  localparam logic [PER_W-1:0] LEAD_ONE = PER_W'(1);
  localparam logic [OVL_W-1:0] OVL_ONE  = OVL_W'(1);

  pfd_state_e       st_q, st_n;
  logic [PER_W-1:0] lead_q, lead_n;
  logic [OVL_W-1:0] ovc_q, ovc_n;
  logic             up_n, dn_n;
  logic [PER_W-1:0] lim, lim_eff;

  always_comb begin
    lim     = limit_sel ? (period >> 3) : (period >> 2);
    lim_eff = (lim == '0) ? LEAD_ONE : lim;
  end

  always_comb begin
    st_n   = st_q;
    lead_n = lead_q;
    ovc_n  = ovc_q;
    up_n   = 1'b0;
    dn_n   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (ref_rise && fb_rise) begin
          st_n = ST_OVL; ovc_n = '0; up_n = 1'b1; dn_n = 1'b1;
        end else if (ref_rise) begin
          st_n = ST_UP; lead_n = LEAD_ONE; up_n = 1'b1;
        end else if (fb_rise) begin
          st_n = ST_DN; dn_n = 1'b1;
        end
      end
      ST_UP: begin
        if (fb_rise) begin
          st_n = ST_OVL; ovc_n = '0; up_n = 1'b1; dn_n = 1'b1;
        end else begin
          up_n = !limit_en || (lead_q < lim_eff);
          if (lead_q != LEAD_MAX) lead_n = lead_q + LEAD_ONE;
        end
      end
      ST_DN: begin
        if (ref_rise) begin
          st_n = ST_OVL; ovc_n = '0; up_n = 1'b1; dn_n = 1'b1;
        end else begin
          dn_n = 1'b1;
        end
      end
      default: begin
        if (ovc_q == ovl) begin
          st_n = ST_IDLE;
        end else begin
          ovc_n = ovc_q + OVL_ONE;
          up_n  = 1'b1;
          dn_n  = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      lead_q <= '0;
      ovc_q  <= '0;
      up_o   <= 1'b0;
      upb_o  <= 1'b1;
      dn_o   <= 1'b0;
      dnb_o  <= 1'b1;
    end else begin
      st_q   <= st_n;
      lead_q <= lead_n;
      ovc_q  <= ovc_n;
      up_o   <= up_n;
      upb_o  <= ~up_n;
      dn_o   <= dn_n;
      dnb_o  <= ~dn_n;
    end
  end

  assert_lead_dir_R1: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && ref_rise && !fb_rise) |=> (up_o && !dn_o));

  assert_clear_together_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(dn_o) |-> !up_o);

  assert_overlap_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(dn_o) |-> $past(up_o));

  assert_ovl_both_R3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_OVL) |-> (up_o && dn_o));

  assert_limit_cut_R4: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_UP && limit_en && lead_q >= lim_eff && !fb_rise) |=> !up_o);

  assert_dn_uncut_R5: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DN && !ref_rise) |=> dn_o);

  assert_complement_R6: assert property (@(posedge clk) disable iff (rst)
    (up_o != upb_o) && (dn_o != dnb_o));
endmodule

// File: rtl/pfd_pulse_limit.sv
module pfd_pulse_limit #(
  parameter int SYNC_STAGES = 2,
  parameter int PER_W       = 12,
  parameter int OVL_W       = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_in,
  input  logic             fbk_in,
  input  logic             limit_en,
  input  logic             limit_sel,
  input  logic [OVL_W-1:0] ovl_cycles,
  output logic             pump_up,
  output logic             pump_up_b,
  output logic             pump_dn,
  output logic             pump_dn_b
);
  logic             ref_rise, fb_rise;
  logic [PER_W-1:0] ref_period;

  pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_edge (
    .clk(clk), .rst(rst), .din(ref_in), .rise(ref_rise)
  );

  pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_fb_edge (
    .clk(clk), .rst(rst), .din(fbk_in), .rise(fb_rise)
  );

  pfd_period_meter #(.PER_W(PER_W)) u_meter (
    .clk(clk), .rst(rst), .tick(ref_rise), .period(ref_period)
  );

  pfd_core #(.PER_W(PER_W), .OVL_W(OVL_W)) u_core (
    .clk(clk), .rst(rst),
    .ref_rise(ref_rise), .fb_rise(fb_rise),
    .limit_en(limit_en), .limit_sel(limit_sel),
    .ovl(ovl_cycles), .period(ref_period),
    .up_o(pump_up), .upb_o(pump_up_b),
    .dn_o(pump_dn), .dnb_o(pump_dn_b)
  );

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (!pump_up && !pump_dn && pump_up_b && pump_dn_b));
endmodule

// File: tb/sim_pfd_pulse_limit.sv
module sim_pfd_pulse_limit;
  localparam int FRAME = 96;
  localparam int REF_AT = 48;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0, fbk_in = 1'b0, limit_en = 1'b0, limit_sel = 1'b0;
  logic [3:0] ovl_cycles = 4'd0;
  logic pump_up, pump_up_b, pump_dn, pump_dn_b;

  pfd_pulse_limit u0 (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fbk_in(fbk_in),
    .limit_en(limit_en), .limit_sel(limit_sel), .ovl_cycles(ovl_cycles),
    .pump_up(pump_up), .pump_up_b(pump_up_b),
    .pump_dn(pump_dn), .pump_dn_b(pump_dn_b)
  );

  always #4 clk = ~clk;

  typedef struct {
    int up; int dn; int both; string tag;
  } exp_t;
  exp_t q[$];

  int total = 0, bad = 0, cycles = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: one frame, ref rises at REF_AT; fb rises `lead` earlier or later
  task automatic frame(input bit fb_first, input int lead, input bit en,
                       input bit sel, input int ov, input int lim, input string tag);
    exp_t e;
    int f, lead_up;
    f = fb_first ? REF_AT - lead : REF_AT + lead;
    e.both = ov + 1;
    if (lead == 0) begin
      e.up = ov + 1; e.dn = ov + 1;
    end else if (!fb_first) begin
      lead_up = (en && lim > 0 && lead > lim) ? lim : lead;
      e.up = lead_up + ov + 1; e.dn = ov + 1;
    end else begin
      e.up = ov + 1; e.dn = lead + ov + 1;
    end
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    limit_en = en; limit_sel = sel; ovl_cycles = 4'(ov);
    for (int i = 0; i < FRAME; i++) begin
      ref_in = (i >= REF_AT && i < REF_AT + 16);
      fbk_in = (i >= f && i < f + 4);
      @(negedge clk);
    end
  endtask

  // monitor: measure pulse lengths, close an item on each pump_dn fall
  int acc_up = 0, acc_dn = 0, acc_b = 0, cmp_bad = 0;
  bit prev_dn = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (pump_up) acc_up++;
      if (pump_dn) acc_dn++;
      if (pump_up && pump_dn) acc_b++;
      if (pump_up_b === pump_up || pump_dn_b === pump_dn) cmp_bad++;
      if (prev_dn && !pump_dn) begin
        if (q.size() == 0) begin
          chk(1'b0, "R2 unexpected pulse", acc_dn, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(acc_up == e.up,   {e.tag, " up width"},   acc_up, e.up);
          chk(acc_dn == e.dn,   {e.tag, " dn width"},   acc_dn, e.dn);
          chk(acc_b  == e.both, {e.tag, " R3 overlap"}, acc_b,  e.both);
          chk(cmp_bad == 0,     "R6 complement",        cmp_bad, 0);
        end
        acc_up = 0; acc_dn = 0; acc_b = 0;
      end
    end
    prev_dn = pump_dn;
  end

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        chk(1'b0, "watchdog", cycles, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!pump_up && !pump_dn && pump_up_b && pump_dn_b, "R8 reset state",
        {pump_up, pump_dn, pump_up_b, pump_dn_b}, 4'b0011);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // period 96: lim 24 for /4, 12 for /8
    frame(0, 10, 0, 0, 0, 0,  "R1 ref leads");
    frame(1, 10, 0, 0, 3, 0,  "R1 fb leads");
    frame(0, 0,  0, 0, 2, 0,  "R2 coincident");
    frame(0, 30, 1, 0, 1, 24, "R4 quarter cut");
    frame(0, 20, 1, 1, 0, 12, "R4 eighth cut");
    frame(1, 20, 1, 1, 0, 12, "R5 dn uncut");
    frame(0, 11, 1, 1, 0, 12, "R4 below limit");
    frame(0, 12, 1, 1, 0, 12, "R4 at limit");
    frame(0, 13, 1, 1, 0, 12, "R4 above limit");
    frame(0, 4,  0, 0, 15, 0, "R3 max overlap");
    frame(0, 30, 0, 0, 1, 24, "R4 bypass");
    // stop the reference long enough that a wrapping counter would read 96
    repeat (4096) @(negedge clk);
    frame(0, 30, 1, 0, 0, 1023, "R9 saturated period");
    frame(0, 30, 1, 0, 0, 24,   "R7 period remeasured");
    repeat (8) @(negedge clk);
    chk(q.size() == 0, "R2 all pulses seen", q.size(), 0);
    // reset in the middle of a reference-leading interval
    limit_en = 1'b0;
    ref_in = 1'b1;
    repeat (6) @(negedge clk);
    chk(pump_up && !pump_dn, "R1 up alone before reset", pump_up, 1);
    rst = 1'b1;
    @(negedge clk);
    chk(!pump_up && !pump_dn && pump_up_b && pump_dn_b, "R8 mid-pulse reset",
        {pump_up, pump_dn, pump_up_b, pump_dn_b}, 4'b0011);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule